// File: doc/BRIEF.md
# Serial Controller Interrupt Event Logic

This block turns the status and event signals of a serial controller into sticky interrupt flags and one interrupt request line. Three status levels are watched: transmit idle (FIFO empty and the last character shifted out), transmit room (FIFO no longer full) and receive available (FIFO no longer empty). For each of these, a mode bit selects whether the flag follows the high level or only the 0-to-1 transition.

For each direction, the block also watches the buffer-active signal of every DMA buffer. A completion flag is raised when that signal falls. Single-cycle pulses for receive overrun and transmit underrun set flags of their own.

Software clears flags by writing ones, and the hardware combines the flags with a per-source enable mask and a top-level enable into a registered request.

Flag vector layout, with NBUF buffers per direction:
- Bit 0: transmit idle.
- Bit 1: transmit room.
- Bit 2: receive available.
- Bits 3 to 3+NBUF-1: transmit buffer completions.
- The next NBUF bits: receive buffer completions.
- Then the receive overrun bit.
- Then the transmit underrun bit, which is the most significant bit.

Top module: `sc_irq_events`

## Requirements
- R1: While `rst` is high at a rising clock edge, all flags and `irq_o` are 0 after that edge.
- R2: With the status mode bit at 0 (level), a status input that is high at an edge sets its flag (bits 0..2) after that edge, and it does so again after a write-1-to-clear for as long as the status stays high.
- R3: With the status mode bit at 1 (edge), the flag is set only when the status is high at an edge and was low at the previous edge; a flag that is cleared while the status stays high remains 0.
- R4: A buffer-active input that was high at the previous edge and is low at the current edge sets its completion flag (bit 3+j for transmit buffer j, bit 3+NBUF+j for receive buffer j); a rising buffer-active input sets nothing.
- R5: An overrun pulse sets bit 3+2*NBUF and an underrun pulse sets bit 4+2*NBUF; these flags stay set after the pulse ends.
- R6: When `clr_we_i` is high at an edge, each flag whose `clr_mask_i` bit is 1 is cleared, and every other flag keeps its value.
- R7: If a clear and a new event for the same flag arrive at the same edge, the flag is 1 after the edge.
- R8: `irq_o` is a register that, after each edge, holds `top_en_i AND OR(flags_o AND src_en_i)`, evaluated on the values present just before that edge; it therefore lags the flags by one cycle.
- R9: While `top_en_i` is 0, `irq_o` is 0 at the next edge, whatever the flags and enables are.
- R10: The previous-value history of the status and buffer-active inputs resets to 0, so in edge mode a status that is high at the first edge after reset counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_i | input | 3 | Status levels: bit0 transmit idle, bit1 transmit room, bit2 receive available |
| stat_edge_i | input | 3 | Per-status trigger mode: 0 level, 1 rising edge |
| tx_busy_i | input | NBUF | Transmit DMA buffer-active signals |
| rx_busy_i | input | NBUF | Receive DMA buffer-active signals |
| rx_ovf_i | input | 1 | Receive overrun pulse |
| tx_und_i | input | 1 | Transmit underrun pulse |
| clr_we_i | input | 1 | Write strobe for the clear mask |
| clr_mask_i | input | 2*NBUF+5 | Write-1-to-clear flag mask |
| src_en_i | input | 2*NBUF+5 | Per-flag interrupt enable |
| top_en_i | input | 1 | Top-level interrupt enable |
| flags_o | output | 2*NBUF+5 | Sticky flag register |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with the default NBUF of 2, which gives nine flags. With this width, completions of buffers A and B in both directions can fall in the same cycle and overlap with status events and error pulses. It also puts the error flags at bits 7 and 8, so that an off-by-one in the index arithmetic lands on a neighbouring flag. Random mode switching, together with sparse clears, reaches the cases where an event and a clear coincide and where the mode changes while a status is held high.

// File: rtl/sc_irq_pkg.sv
package sc_irq_pkg;

    localparam int STAT_N = 3;

    typedef enum logic [1:0] {
        ST_TX_IDLE  = 2'd0,
        ST_TX_ROOM  = 2'd1,
        ST_RX_AVAIL = 2'd2
    } stat_src_e;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_e;

    typedef struct packed {
        logic tx_und;
        logic rx_ovf;
    } err_evt_t;

    function automatic int flag_total(input int nbuf);
        return STAT_N + 2 * nbuf + 2;
    endfunction

    function automatic int txdma_base(input int nbuf);
        return STAT_N + 0 * nbuf;
    endfunction

    function automatic int rxdma_base(input int nbuf);
        return STAT_N + nbuf;
    endfunction

    function automatic int ovf_idx(input int nbuf);
        return STAT_N + 2 * nbuf;
    endfunction

    function automatic int und_idx(input int nbuf);
        return STAT_N + 2 * nbuf + 1;
    endfunction

endpackage

// File: rtl/sc_irq_edge_det.sv
module sc_irq_edge_det #(
    parameter int W       = 1,
    parameter bit FALLING = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] evt_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sig_i;
    end

    generate
        if (FALLING) begin : g_fall
            assign evt_o = prev_q & ~sig_i;
        end else begin : g_rise
            assign evt_o = sig_i & ~prev_q;
        end
    endgenerate
endmodule

// File: rtl/sc_irq_stat_trig.sv
module sc_irq_stat_trig
    import sc_irq_pkg::*;
#(
    parameter int N = STAT_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] mode_i,
    output logic [N-1:0] evt_o
);
    logic [N-1:0] rise;

    sc_irq_edge_det #(.W(N), .FALLING(1'b0)) u_rise (
        .clk   (clk),
        .rst   (rst),
        .sig_i (lvl_i),
        .evt_o (rise)
    );

    for (genvar i = 0; i < N; i++) begin : g_src
        trig_e md;
        assign md       = trig_e'(mode_i[i]);
        assign evt_o[i] = (md == TRIG_EDGE) ? rise[i] : lvl_i[i];
    end
endmodule

// File: rtl/sc_irq_flag_bank.sv
module sc_irq_flag_bank #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_mask_i,
    output logic [W-1:0] flags_o
);
    logic [W-1:0] flags_q, flags_d, clr_eff;

    always_comb begin
        clr_eff = clr_we_i ? clr_mask_i : '0;
        // a fresh event overrides a simultaneous clear
        flags_d = (flags_q & ~clr_eff) | set_i;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/sc_irq_out_gate.sv
module sc_irq_out_gate #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] flags_i,
    input  logic [W-1:0] en_i,
    input  logic         top_en_i,
    output logic         irq_o
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= top_en_i & (|(flags_i & en_i));
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/sc_irq_events.sv
module sc_irq_events
    import sc_irq_pkg::*;
#(
    parameter  int NBUF = 2,
    localparam int NF   = flag_total(NBUF)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_N-1:0] stat_i,
    input  logic [STAT_N-1:0] stat_edge_i,
    input  logic [NBUF-1:0]   tx_busy_i,
    input  logic [NBUF-1:0]   rx_busy_i,
    input  logic              rx_ovf_i,
    input  logic              tx_und_i,
    input  logic              clr_we_i,
    input  logic [NF-1:0]     clr_mask_i,
    input  logic [NF-1:0]     src_en_i,
    input  logic              top_en_i,
    output logic [NF-1:0]     flags_o,
    output logic              irq_o
);
    logic [STAT_N-1:0] stat_evt;
    logic [NBUF-1:0]   txd_evt, rxd_evt;
    err_evt_t          err;
    logic [NF-1:0]     set_vec;

    sc_irq_stat_trig #(.N(STAT_N)) u_stat (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (stat_i),
        .mode_i (stat_edge_i),
        .evt_o  (stat_evt)
    );

    sc_irq_edge_det #(.W(NBUF), .FALLING(1'b1)) u_txd (
        .clk   (clk),
        .rst   (rst),
        .sig_i (tx_busy_i),
        .evt_o (txd_evt)
    );

    sc_irq_edge_det #(.W(NBUF), .FALLING(1'b1)) u_rxd (
        .clk   (clk),
        .rst   (rst),
        .sig_i (rx_busy_i),
        .evt_o (rxd_evt)
    );

    always_comb begin
        err.rx_ovf = rx_ovf_i;
        err.tx_und = tx_und_i;
        set_vec = '0;
        set_vec[STAT_N-1:0]                          = stat_evt;
        set_vec[txdma_base(NBUF) +: NBUF]            = txd_evt;
        set_vec[rxdma_base(NBUF) +: NBUF]            = rxd_evt;
        set_vec[ovf_idx(NBUF)]                       = err.rx_ovf;
        set_vec[und_idx(NBUF)]                       = err.tx_und;
    end

    sc_irq_flag_bank #(.W(NF)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .set_i      (set_vec),
        .clr_we_i   (clr_we_i),
        .clr_mask_i (clr_mask_i),
        .flags_o    (flags_o)
    );

    sc_irq_out_gate #(.W(NF)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .flags_i  (flags_o),
        .en_i     (src_en_i),
        .top_en_i (top_en_i),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/sc_irq_events_chk.sv
module sc_irq_events_chk
    import sc_irq_pkg::*;
#(
    parameter  int NBUF = 2,
    localparam int NF   = flag_total(NBUF)
) (
    input logic              clk,
    input logic              rst,
    input logic [STAT_N-1:0] stat_i,
    input logic [STAT_N-1:0] stat_edge_i,
    input logic [NBUF-1:0]   tx_busy_i,
    input logic [NBUF-1:0]   rx_busy_i,
    input logic              rx_ovf_i,
    input logic              tx_und_i,
    input logic              clr_we_i,
    input logic [NF-1:0]     clr_mask_i,
    input logic [NF-1:0]     src_en_i,
    input logic              top_en_i,
    input logic [NF-1:0]     flags_o,
    input logic              irq_o
);
    logic [NF-1:0] clr_eff;
    logic [NF-1:0] keep_q;

    assign clr_eff = clr_we_i ? clr_mask_i : '0;

    always_ff @(posedge clk) begin
        if (rst) keep_q <= '0;
        else     keep_q <= flags_o & ~clr_eff;
    end

    // R6: uncleared flags never drop
    assert_flag_kept_R6: assert property (@(posedge clk) disable iff (rst)
        ((keep_q & ~flags_o) == '0));

    for (genvar i = 0; i < STAT_N; i++) begin : g_stat
        assert_level_set_R2: assert property (@(posedge clk) disable iff (rst)
            (!stat_edge_i[i] && stat_i[i]) |=> flags_o[i]);
        assert_edge_hold_R3: assert property (@(posedge clk) disable iff (rst)
            (stat_edge_i[i] && stat_i[i] && $past(stat_i[i]) && !$past(rst)
             && clr_eff[i]) |=> !flags_o[i]);
    end

    for (genvar j = 0; j < NBUF; j++) begin : g_buf
        assert_txdone_fall_R4: assert property (@(posedge clk) disable iff (rst)
            ($fell(tx_busy_i[j]) && !$past(rst)) |=> flags_o[txdma_base(NBUF)+j]);
        assert_rxdone_fall_R4: assert property (@(posedge clk) disable iff (rst)
            ($fell(rx_busy_i[j]) && !$past(rst)) |=> flags_o[rxdma_base(NBUF)+j]);
    end

    assert_ovf_set_R5: assert property (@(posedge clk) disable iff (rst)
        rx_ovf_i |=> flags_o[ovf_idx(NBUF)]);
    assert_und_set_R5: assert property (@(posedge clk) disable iff (rst)
        tx_und_i |=> flags_o[und_idx(NBUF)]);

    assert_irq_raise_R8: assert property (@(posedge clk) disable iff (rst)
        (top_en_i && (|(flags_o & src_en_i))) |=> irq_o);
    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
        !top_en_i |=> !irq_o);
endmodule

bind sc_irq_events sc_irq_events_chk #(.NBUF(NBUF)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .stat_i      (stat_i),
    .stat_edge_i (stat_edge_i),
    .tx_busy_i   (tx_busy_i),
    .rx_busy_i   (rx_busy_i),
    .rx_ovf_i    (rx_ovf_i),
    .tx_und_i    (tx_und_i),
    .clr_we_i    (clr_we_i),
    .clr_mask_i  (clr_mask_i),
    .src_en_i    (src_en_i),
    .top_en_i    (top_en_i),
    .flags_o     (flags_o),
    .irq_o       (irq_o)
);

// File: tb/sc_irq_events_tb.sv
`timescale 1ns/100ps
module sc_irq_events_tb_top;
    localparam int NB = 2;
    localparam int NF = sc_irq_pkg::flag_total(NB);
    localparam int OVF = 3 + 2*NB;
    localparam int UND = 4 + 2*NB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0]    stat_i = '0, stat_edge_i = '0;
    logic [NB-1:0] tx_busy_i = '0, rx_busy_i = '0;
    logic          rx_ovf_i = 1'b0, tx_und_i = 1'b0, clr_we_i = 1'b0, top_en_i = 1'b0;
    logic [NF-1:0] clr_mask_i = '0, src_en_i = '0;
    logic [NF-1:0] flags_o;
    logic          irq_o;

    int n_total = 0;
    int n_bad   = 0;

    logic [NF-1:0] m_flags = '0;
    logic [2:0]    m_pstat = '0;
    logic [NB-1:0] m_ptx = '0, m_prx = '0;
    logic          m_irq = 1'b0;

    always #2.5 clk = ~clk;

    sc_irq_events #(.NBUF(NB)) dut_i (
        .clk(clk), .rst(rst), .stat_i(stat_i), .stat_edge_i(stat_edge_i),
        .tx_busy_i(tx_busy_i), .rx_busy_i(rx_busy_i), .rx_ovf_i(rx_ovf_i),
        .tx_und_i(tx_und_i), .clr_we_i(clr_we_i), .clr_mask_i(clr_mask_i),
        .src_en_i(src_en_i), .top_en_i(top_en_i), .flags_o(flags_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NF-1:0] model_events();
        logic [NF-1:0] ev = '0;
        for (int i = 0; i < 3; i++)
            ev[i] = stat_edge_i[i] ? (stat_i[i] & ~m_pstat[i]) : stat_i[i];
        for (int j = 0; j < NB; j++) begin
            ev[3+j]    = m_ptx[j] & ~tx_busy_i[j];
            ev[3+NB+j] = m_prx[j] & ~rx_busy_i[j];
        end
        ev[OVF] = rx_ovf_i;
        ev[UND] = tx_und_i;
        return ev;
    endfunction

    task automatic step();
        logic [NF-1:0] nf;
        logic          ni;
        if (rst) begin
            nf = '0; ni = 1'b0;
        end else begin
            nf = (m_flags & ~(clr_we_i ? clr_mask_i : '0)) | model_events();
            ni = top_en_i & (|(m_flags & src_en_i));
        end
        @(posedge clk);
        m_flags = nf; m_irq = ni;
        m_pstat = rst ? '0 : stat_i;
        m_ptx   = rst ? '0 : tx_busy_i;
        m_prx   = rst ? '0 : rx_busy_i;
        #1;
        chk("model flags (R2 R3 R4 R5 R6 R7)", 32'(flags_o), 32'(m_flags));
        chk("model irq (R8 R9)", 32'(irq_o), 32'(m_irq));
        clr_we_i = 1'b0; rx_ovf_i = 1'b0; tx_und_i = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; step(); step(); rst = 1'b0;
    endtask

    task automatic clear_all();
        clr_we_i = 1'b1; clr_mask_i = '1; step();
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #1;
        do_reset();
        chk("R1 reset flags", 32'(flags_o), 0);
        chk("R1 reset irq", 32'(irq_o), 0);

        // R10: edge mode, status high from reset on counts as a rise
        stat_edge_i = 3'b111; stat_i = 3'b001; rst = 1'b1; step(); step(); rst = 1'b0;
        step();
        chk("R10 first edge after reset", 32'(flags_o[0]), 1);
        stat_i = '0; step(); clear_all();

        // R2 level mode re-set while high
        stat_edge_i = 3'b000; stat_i = 3'b001; step();
        chk("R2 level set", 32'(flags_o[0]), 1);
        clr_we_i = 1'b1; clr_mask_i = NF'(1); step();
        chk("R2 level re-set after clear", 32'(flags_o[0]), 1);
        stat_i = '0; clr_we_i = 1'b1; clr_mask_i = NF'(1); step();
        chk("R2 clear once low", 32'(flags_o[0]), 0);

        // R3 edge mode
        stat_edge_i = 3'b111; stat_i = 3'b010; step();
        chk("R3 rise sets", 32'(flags_o[1]), 1);
        clr_we_i = 1'b1; clr_mask_i = NF'(2); step();
        chk("R3 cleared while high", 32'(flags_o[1]), 0);
        step();
        chk("R3 stays clear", 32'(flags_o[1]), 0);
        stat_i = '0; step(); stat_i = 3'b010; step();
        chk("R3 new rise sets", 32'(flags_o[1]), 1);
        stat_i = '0; clear_all();

        // R4 DMA completion on fall only
        tx_busy_i = 2'b01; rx_busy_i = 2'b10; step();
        chk("R4 rise sets nothing", 32'(flags_o), 0);
        tx_busy_i = 2'b00; rx_busy_i = 2'b00; step();
        chk("R4 tx buffer A done", 32'(flags_o[3]), 1);
        chk("R4 rx buffer B done", 32'(flags_o[3+NB+1]), 1);
        chk("R4 others untouched", 32'(flags_o & ~(NF'(1) << 3) & ~(NF'(1) << (4+NB))), 0);

        // R6 selective clear
        clr_we_i = 1'b1; clr_mask_i = NF'(1) << 3; step();
        chk("R6 selected bit cleared", 32'(flags_o[3]), 0);
        chk("R6 other bit kept", 32'(flags_o[3+NB+1]), 1);
        clear_all();

        // R5 error pulses sticky
        rx_ovf_i = 1'b1; step();
        chk("R5 overrun flag", 32'(flags_o[OVF]), 1);
        tx_und_i = 1'b1; step(); step();
        chk("R5 underrun flag sticky", 32'(flags_o[UND]), 1);
        chk("R5 overrun still set", 32'(flags_o[OVF]), 1);
        clear_all();

        // R7 event wins over clear
        stat_i = 3'b100; clr_we_i = 1'b1; clr_mask_i = '1; step();
        chk("R7 event beats clear", 32'(flags_o[2]), 1);
        stat_i = '0; clear_all();

        // R8 registered irq lag, R9 gating
        src_en_i = NF'(1) << OVF; top_en_i = 1'b1; rx_ovf_i = 1'b1; step();
        chk("R8 irq lags flag", 32'(irq_o), 0);
        step();
        chk("R8 irq raised", 32'(irq_o), 1);
        top_en_i = 1'b0; step();
        chk("R9 top enable off", 32'(irq_o), 0);
        step();
        chk("R9 stays off", 32'(irq_o), 0);
        clear_all();

        // random phase
        for (int c = 0; c < 3000; c++) begin
            if ($urandom_range(0, 15) == 0) stat_edge_i = 3'($urandom);
            stat_i     = 3'($urandom);
            tx_busy_i  = NB'($urandom);
            rx_busy_i  = NB'($urandom);
            rx_ovf_i   = ($urandom_range(0, 7) == 0);
            tx_und_i   = ($urandom_range(0, 7) == 0);
            clr_we_i   = ($urandom_range(0, 2) == 0);
            clr_mask_i = NF'($urandom);
            src_en_i   = NF'($urandom);
            top_en_i   = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 199) == 0) rst = 1'b1;
            step();
            rst = 1'b0;
        end

        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule